// File: doc/BRIEF.md
# Execute and Memory Operand Steering

This block carries one decoded instruction per cycle from the point where its register operands have been read to the value that goes back into the register file. It picks the arithmetic operands, runs a small arithmetic unit (add, subtract, shift left) and forms the effective address of loads and stores as a base register plus a constant. It drives a word-addressed synchronous data memory and then chooses the write-back value, either the computed result or the word the memory returned.

Link instructions (jump-and-link forms) use PC+4 as the first operand in place of a register value, and their result is that return address. Store data comes from the second source register. It travels beside the computed address and reaches the memory port in the same cycle as that address. The block has two register stages. The first holds the arithmetic result and the store data, and it drives the memory request. The second holds the write-back control while the memory answers.

Top module: `xm_steer`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_we`, `mem_re` and `wb_en` are low.
- R2: An accepted link instruction (`in_kind` = 5) writes `in_pc + 4` to `in_rd`, and the register operand values have no effect. Its write-back appears two clock edges after acceptance.
- R3: A register-register instruction (`in_kind` = 1) takes its second operand from `in_rs2_val`.
- R4: A register-immediate instruction (`in_kind` = 2) takes its second operand from `in_imm`, and `in_rs2_val` has no effect.
- R5: For kinds 1 and 2, `in_op` 3'b000 adds and 3'b001 subtracts (first minus second), both modulo 2^DATA_W. 3'b010 shifts the first operand left by the low log2(DATA_W) bits of the second operand. Every other code adds.
- R6: A source index of 0 reads as zero, whatever value is present on the matching `*_val` input.
- R7: A load (`in_kind` = 3) or store (`in_kind` = 4) presents the low ADDR_W bits of `rs1 + in_imm` on `mem_addr` one clock edge after acceptance. It is always an addition, whatever `in_op` holds. `mem_re` is high only for loads.
- R8: A store raises `mem_we` with `mem_wdata` equal to its second source value, in the same cycle as its address. A store never produces a register write.
- R9: A load writes the word the memory returns on `mem_rdata` (one cycle after the request) to `in_rd`, two edges after acceptance.
- R10: For every kind other than load, the write-back value is the arithmetic result, whatever `mem_rdata` holds.
- R11: `wb_en` is high only for kinds 1, 2, 3 and 5 with a nonzero `in_rd`, and `wb_rd` carries that index. A cycle with `in_valid` low, `in_kind` 0 (no-op) or an unused kind (6, 7) writes nothing.
- R12: `mem_we` and `mem_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_kind | input | 3 | 0 nop, 1 reg-reg, 2 reg-imm, 3 load, 4 store, 5 link |
| in_op | input | 3 | Arithmetic code for kinds 1 and 2 |
| in_pc | input | DATA_W | Address of the instruction |
| in_rs1_idx | input | REG_AW | First source register index |
| in_rs1_val | input | DATA_W | First source register value |
| in_rs2_idx | input | REG_AW | Second source register index |
| in_rs2_val | input | DATA_W | Second source register value |
| in_imm | input | DATA_W | Sign-extended immediate |
| in_rd | input | REG_AW | Destination register index |
| mem_addr | output | ADDR_W | Word address to data memory |
| mem_wdata | output | DATA_W | Store data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read request |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the request |
| wb_en | output | 1 | Register write enable |
| wb_rd | output | REG_AW | Register write index |
| wb_data | output | DATA_W | Register write value |

## Verification
The memory request of an instruction accepted at edge k is visible just after edge k. Its write-back is visible just after edge k+1, and for a load that is the point where the memory's registered answer has also arrived. The driver pushes one expectation per cycle, idle cycles included. The monitor wakes 1 ns after every rising edge. It compares the memory port against the item accepted at that edge and the write-back port against the item accepted one edge earlier. Expected load data comes from a shadow copy of the bench memory that the driver updates in program order, so a load placed right behind a store to the same word checks the forwarding-free ordering.

// File: rtl/xm_pkg.sv
package xm_pkg;

   typedef enum logic [2:0] {
      K_NOP   = 3'd0,
      K_RR    = 3'd1,
      K_RI    = 3'd2,
      K_LOAD  = 3'd3,
      K_STORE = 3'd4,
      K_LINK  = 3'd5
   } xm_kind_e;

   typedef enum logic [2:0] {
      OP_ADD = 3'b000,
      OP_SUB = 3'b001,
      OP_SHL = 3'b010
   } xm_op_e;

   function automatic logic kind_writes(input xm_kind_e k);
      return (k == K_RR) || (k == K_RI) || (k == K_LOAD) || (k == K_LINK);
   endfunction

endpackage

// File: rtl/xm_opsel.sv
module xm_opsel #(
   parameter int DATA_W    = 32,
   parameter int REG_AW    = 5,
   parameter int ZERO_REG0 = 1
) (
   input  xm_pkg::xm_kind_e    kind,
   input  logic [2:0]          op_in,
   input  logic [DATA_W-1:0]   pc,
   input  logic [REG_AW-1:0]   rs1_idx,
   input  logic [DATA_W-1:0]   rs1_val,
   input  logic [REG_AW-1:0]   rs2_idx,
   input  logic [DATA_W-1:0]   rs2_val,
   input  logic [DATA_W-1:0]   imm,
   output logic [DATA_W-1:0]   opa,
   output logic [DATA_W-1:0]   opb,
   output logic [2:0]          alu_op,
   output logic [DATA_W-1:0]   st_data
);
   import xm_pkg::*;

   localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);

   logic [DATA_W-1:0] src1, src2;

   generate
      if (ZERO_REG0 != 0) begin : g_zero_reg
         assign src1 = (rs1_idx == '0) ? '0 : rs1_val;
         assign src2 = (rs2_idx == '0) ? '0 : rs2_val;
      end else begin : g_plain_reg
         assign src1 = rs1_val;
         assign src2 = rs2_val;
      end
   endgenerate

   always_comb begin
      opa    = src1;
      opb    = '0;
      alu_op = OP_ADD;
      unique case (kind)
         K_RR: begin
            opb    = src2;
            alu_op = op_in;
         end
         K_RI: begin
            opb    = imm;
            alu_op = op_in;
         end
         K_LOAD, K_STORE: opb = imm;
         K_LINK: opa = pc + PC_STEP;
         default: opa = '0;
      endcase
   end

   assign st_data = src2;

endmodule

// File: rtl/xm_alu.sv
module xm_alu #(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   import xm_pkg::*;

   localparam int SHAMT_W = $clog2(DATA_W);

   logic [SHAMT_W-1:0] shamt;
   assign shamt = b[SHAMT_W-1:0];

   always_comb begin
      unique case (op)
         OP_SUB:  y = a - b;
         OP_SHL:  y = a << shamt;
         default: y = a + b;
      endcase
   end

endmodule

// File: rtl/xm_wbsel.sv
module xm_wbsel #(
   parameter int DATA_W = 32
) (
   input  logic              take_mem,
   input  logic [DATA_W-1:0] result,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data
);
   assign data = take_mem ? rdata : result;
endmodule

// File: rtl/xm_steer.sv
module xm_steer #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 10,
   parameter int REG_AW    = 5,
   parameter int ZERO_REG0 = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_kind,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_pc,
   input  logic [REG_AW-1:0] in_rs1_idx,
   input  logic [DATA_W-1:0] in_rs1_val,
   input  logic [REG_AW-1:0] in_rs2_idx,
   input  logic [DATA_W-1:0] in_rs2_val,
   input  logic [DATA_W-1:0] in_imm,
   input  logic [REG_AW-1:0] in_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wb_en,
   output logic [REG_AW-1:0] wb_rd,
   output logic [DATA_W-1:0] wb_data
);
   import xm_pkg::*;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("xm_steer: DATA_W must be a power of two of at least 8");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("xm_steer: ADDR_W must lie in 1..DATA_W");
   end
   if (REG_AW < 1) begin : g_bad_reg_aw
      $error("xm_steer: REG_AW must be positive");
   end

   // ---------------- issue: operand steering and arithmetic
   xm_kind_e          kind_in;
   logic [DATA_W-1:0] opa, opb, alu_y, st_data;
   logic [2:0]        alu_op;

   assign kind_in = in_valid ? xm_kind_e'(in_kind) : K_NOP;

   xm_opsel #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .ZERO_REG0(ZERO_REG0)
   ) opsel_i (
      .kind(kind_in), .op_in(in_op), .pc(in_pc),
      .rs1_idx(in_rs1_idx), .rs1_val(in_rs1_val),
      .rs2_idx(in_rs2_idx), .rs2_val(in_rs2_val),
      .imm(in_imm), .opa(opa), .opb(opb), .alu_op(alu_op),
      .st_data(st_data)
   );

   xm_alu #(.DATA_W(DATA_W)) alu_i (
      .op(alu_op), .a(opa), .b(opb), .y(alu_y)
   );

   // ---------------- stage 1: result, store data, memory request
   xm_kind_e          ex_kind;
   logic [DATA_W-1:0] ex_res;
   logic [DATA_W-1:0] ex_sdata;
   logic [REG_AW-1:0] ex_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ex_kind  <= K_NOP;
         ex_res   <= '0;
         ex_sdata <= '0;
         ex_rd    <= '0;
      end else begin
         ex_kind  <= kind_in;
         ex_res   <= alu_y;
         ex_sdata <= st_data;
         ex_rd    <= in_rd;
      end
   end

   assign mem_addr  = ex_res[ADDR_W-1:0];
   assign mem_wdata = ex_sdata;
   assign mem_we    = (ex_kind == K_STORE);
   assign mem_re    = (ex_kind == K_LOAD);

   // ---------------- stage 2: write-back control while memory answers
   logic              wb_load_q;
   logic              wb_en_q;
   logic [REG_AW-1:0] wb_rd_q;
   logic [DATA_W-1:0] wb_res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_load_q <= 1'b0;
         wb_en_q   <= 1'b0;
         wb_rd_q   <= '0;
         wb_res_q  <= '0;
      end else begin
         wb_load_q <= (ex_kind == K_LOAD);
         wb_en_q   <= kind_writes(ex_kind) && (ex_rd != '0);
         wb_rd_q   <= ex_rd;
         wb_res_q  <= ex_res;
      end
   end

   xm_wbsel #(.DATA_W(DATA_W)) wbsel_i (
      .take_mem(wb_load_q), .result(wb_res_q), .rdata(mem_rdata),
      .data(wb_data)
   );

   assign wb_en = wb_en_q;
   assign wb_rd = wb_rd_q;

   // ---------------- assertions
   assert_mem_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_store_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !wb_en);

   assert_rd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_rd != '0));

   assert_load_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && $past(mem_re)) |-> (wb_data == mem_rdata));

   assert_result_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !$past(mem_re)) |-> (wb_data == $past(ex_res)));

endmodule

// File: tb/xm_steer_tb.sv
`timescale 1ns/1ps
module xm_steer_tb_top;

   localparam int DW = 32;
   localparam int AW = 10;
   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    in_kind = '0, in_op = '0;
   logic [DW-1:0] in_pc = '0, in_rs1_val = '0, in_rs2_val = '0, in_imm = '0;
   logic [RW-1:0] in_rs1_idx = '0, in_rs2_idx = '0, in_rd = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, wb_data;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_we, mem_re, wb_en;
   logic [RW-1:0] wb_rd;

   always #2.5 clk = ~clk;

   xm_steer #(.DATA_W(DW), .ADDR_W(AW), .REG_AW(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_op(in_op), .in_pc(in_pc), .in_rs1_idx(in_rs1_idx),
      .in_rs1_val(in_rs1_val), .in_rs2_idx(in_rs2_idx),
      .in_rs2_val(in_rs2_val), .in_imm(in_imm), .in_rd(in_rd),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .mem_rdata(mem_rdata), .wb_en(wb_en),
      .wb_rd(wb_rd), .wb_data(wb_data)
   );

   // bench memory and the driver's shadow copy
   logic [DW-1:0] bmem   [1024];
   logic [DW-1:0] shadow [1024];
   initial begin
      for (int i = 0; i < 1024; i++) begin
         bmem[i]   = i * 32'h0101_0101 + 32'd7;
         shadow[i] = i * 32'h0101_0101 + 32'd7;
      end
   end
   always @(posedge clk) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= bmem[mem_addr];
   end

   typedef struct {
      logic          we, re;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
      logic          wen;
      logic [RW-1:0] rd;
      logic [DW-1:0] data;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // driver: applies one instruction and pushes what it must produce
   task automatic issue(input bit v, input logic [2:0] kind, input logic [2:0] op,
                        input logic [DW-1:0] pc,
                        input logic [RW-1:0] r1i, input logic [DW-1:0] r1v,
                        input logic [RW-1:0] r2i, input logic [DW-1:0] r2v,
                        input logic [DW-1:0] imm, input logic [RW-1:0] rd,
                        input string tag);
      exp_t e;
      logic [DW-1:0] a, b, y;
      logic [2:0]    k;
      @(negedge clk);
      in_valid = v; in_kind = kind; in_op = op; in_pc = pc;
      in_rs1_idx = r1i; in_rs1_val = r1v; in_rs2_idx = r2i; in_rs2_val = r2v;
      in_imm = imm; in_rd = rd;
      k = v ? kind : 3'd0;
      a = (r1i == 0) ? '0 : r1v;
      b = (r2i == 0) ? '0 : r2v;
      if (k == 3'd5) begin
         y = pc + 32'd4;
      end else if (k == 3'd3 || k == 3'd4) begin
         y = a + imm;
      end else begin
         if (k == 3'd2) b = imm;
         case (op)
            3'b001:  y = a - b;
            3'b010:  y = a << b[4:0];
            default: y = a + b;
         endcase
      end
      e.tag   = tag;
      e.we    = (k == 3'd4);
      e.re    = (k == 3'd3);
      e.addr  = y[AW-1:0];
      e.wdata = (r2i == 0) ? '0 : r2v;
      e.wen   = (k == 3'd1 || k == 3'd2 || k == 3'd3 || k == 3'd5) && (rd != 0);
      e.rd    = rd;
      e.data  = (k == 3'd3) ? shadow[y[AW-1:0]] : y;
      if (k == 3'd4) shadow[y[AW-1:0]] = e.wdata;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++)
         issue(1'b0, 3'd0, 3'd0, '0, '0, '0, '0, '0, '0, '0, "idle");
   endtask

   // monitor: memory port for the item accepted at this edge,
   // write-back port for the item accepted one edge earlier
   initial begin
      exp_t pend;
      bit   pend_v = 1'b0;
      exp_t cur;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (pend_v) begin
               chk(pend.tag, "wb_en", DW'(wb_en), DW'(pend.wen));
               if (pend.wen) begin
                  chk(pend.tag, "wb_rd", DW'(wb_rd), DW'(pend.rd));
                  chk(pend.tag, "wb_data", wb_data, pend.data);
               end
            end
            pend_v = 1'b0;
            if (exp_q.size() > 0) begin
               cur = exp_q.pop_front();
               chk({cur.tag, " R12"}, "mem_we", DW'(mem_we), DW'(cur.we));
               chk({cur.tag, " R12"}, "mem_re", DW'(mem_re), DW'(cur.re));
               if (cur.we || cur.re)
                  chk(cur.tag, "mem_addr", DW'(mem_addr), DW'(cur.addr));
               if (cur.we)
                  chk(cur.tag, "mem_wdata", mem_wdata, cur.wdata);
               pend   = cur;
               pend_v = 1'b1;
            end
         end
      end
   end

   initial begin
      repeat (4000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset holds the outputs low, even with a valid input applied
      @(negedge clk);
      in_valid = 1'b1; in_kind = 3'd4; in_rd = 5'd3;
      repeat (3) @(negedge clk);
      chk("R1", "mem_we in reset", DW'(mem_we), '0);
      chk("R1", "mem_re in reset", DW'(mem_re), '0);
      chk("R1", "wb_en in reset",  DW'(wb_en),  '0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "mem_we after reset", DW'(mem_we), '0);
      chk("R1", "wb_en after reset",  DW'(wb_en),  '0);

      issue(1, 3'd1, 3'b000, 32'h40, 5'd5, 32'd100, 5'd6, 32'd23, 32'hdead, 5'd7, "R3 R5 add");
      issue(1, 3'd1, 3'b001, 32'h44, 5'd5, 32'd10,  5'd6, 32'd30, 32'h0, 5'd8, "R5 sub wrap");
      issue(1, 3'd1, 3'b010, 32'h48, 5'd1, 32'd3,   5'd2, 32'h24, 32'h0, 5'd9, "R5 shl low bits");
      issue(1, 3'd1, 3'b111, 32'h4c, 5'd1, 32'd9,   5'd2, 32'd4,  32'h0, 5'd10, "R5 other code adds");
      issue(1, 3'd2, 3'b000, 32'h50, 5'd3, 32'd50,  5'd4, 32'hffff, 32'd7, 5'd11, "R4 imm add");
      issue(1, 3'd2, 3'b001, 32'h54, 5'd3, 32'd50,  5'd4, 32'd1, 32'hffff_fffe, 5'd12, "R4 R5 imm sub");
      issue(1, 3'd1, 3'b000, 32'h58, 5'd0, 32'd999, 5'd0, 32'd888, 32'h0, 5'd13, "R6 both zero regs");
      issue(1, 3'd2, 3'b000, 32'h5c, 5'd0, 32'd999, 5'd0, 32'd0, 32'd5, 5'd14, "R6 zero base");
      issue(1, 3'd5, 3'b001, 32'h100, 5'd7, 32'h1234, 5'd8, 32'h55, 32'd77, 5'd31, "R2 link");
      issue(1, 3'd5, 3'b000, 32'h200, 5'd7, 32'h1234, 5'd8, 32'h55, 32'd0, 5'd0, "R11 link rd0");
      issue(1, 3'd4, 3'b010, 32'h60, 5'd4, 32'd20, 5'd6, 32'hcafe_f00d, 32'd5, 5'd15, "R7 R8 store");
      issue(1, 3'd3, 3'b001, 32'h64, 5'd4, 32'd20, 5'd6, 32'h0, 32'd5, 5'd16, "R7 R9 load after store");
      issue(1, 3'd1, 3'b000, 32'h68, 5'd1, 32'd1, 5'd2, 32'd2, 32'h0, 5'd17, "R10 alu after load");
      issue(1, 3'd3, 3'b000, 32'h6c, 5'd2, 32'h0001_2345, 5'd0, 32'h0, 32'hffff_fff0, 5'd18, "R7 R9 addr truncation");
      issue(1, 3'd4, 3'b000, 32'h70, 5'd2, 32'd40, 5'd0, 32'h7777, 32'd0, 5'd19, "R6 R8 store zero data");
      issue(1, 3'd3, 3'b000, 32'h74, 5'd2, 32'd40, 5'd0, 32'h0, 32'd0, 5'd20, "R9 load zeroed word");
      issue(1, 3'd3, 3'b000, 32'h78, 5'd2, 32'd100, 5'd0, 32'h0, 32'd0, 5'd0, "R11 load rd0");
      issue(1, 3'd2, 3'b000, 32'h7c, 5'd2, 32'd8, 5'd0, 32'h0, 32'd1, 5'd0, "R11 alu rd0");
      issue(0, 3'd1, 3'b000, 32'h80, 5'd2, 32'd8, 5'd3, 32'd1, 32'd1, 5'd21, "R11 invalid");
      issue(1, 3'd0, 3'b000, 32'h84, 5'd2, 32'd8, 5'd3, 32'd1, 32'd1, 5'd22, "R11 nop");
      issue(1, 3'd7, 3'b000, 32'h88, 5'd2, 32'd8, 5'd3, 32'd1, 32'd1, 5'd23, "R11 unused kind");
      issue(1, 3'd2, 3'b010, 32'h8c, 5'd2, 32'd1, 5'd3, 32'd0, 32'h3f, 5'd24, "R4 R5 shl imm");
      idle(4);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule